// File: doc/BRIEF.md
# Round-Robin Task Scheduler with Memory-Resident Ready List

This block picks which task runs, in hardware. Runnable tasks are kept in a singly linked list that lives in ordinary word-addressed memory. Each task is identified by the word address of its descriptor. The descriptor holds a link word at a fixed offset (`NEXT_OFS`), and that word points to the next runnable task. Two internal registers hold the head and the tail of the list. The head is the task that is running now, and it appears on `cur_task`.

The running task keeps the processor for `QUANTUM` clock cycles. If another task is queued when that time runs out, the head moves to the tail and its successor takes over. New tasks and woken tasks enter through two valid/ready request ports and are linked in at the tail, even while a task is running. The running task gives up its place through a third valid/ready port, `leave`. It does this when it finishes, or when it must wait on an input, an output or a timer. A task that leaves is not put back in the list. When a blocked task can continue, it comes back through the wake port.

All list updates go through a single 32-bit synchronous memory port. Read data returns one cycle after the read request. Because of this, every list operation takes a few cycles, and the request ports apply back-pressure while an operation is running.

Top module: `rr_task_sched`

## Requirements
- R1: While reset is active and after it is released, `cur_valid`, `switch_pulse`, `mem_en` and `leave_ready` are 0, and `add_ready` and `wake_ready` are 1.
- R2: A task added to an empty list becomes current three cycles after its handshake cycle, together with a `switch_pulse`.
- R3: Tasks are served in round-robin order. An added or woken task is linked behind the tail, and a task whose quantum expires while others are queued is moved behind the tail.
- R4: When another task is queued and no request arrives, consecutive `switch_pulse`s from quantum expiry are exactly `QUANTUM`+3 cycles apart.
- R5: When the running task is the only one in the list, its quantum expiry does not switch tasks and does not touch memory. The quantum simply starts again.
- R6: A handshake on `leave` removes the current task, and the task is never requeued. Its successor becomes current three cycles after the handshake cycle, with a `switch_pulse`.
- R7: When the only task leaves, `cur_valid` drops to 0 with no `switch_pulse`, and a later add is handled as an add to an empty list.
- R8: The link word of task T is at address T+`NEXT_OFS`. It holds the successor's address, zero-extended to 32 bits. The last entry's link word is all zeros (null), and a head value of zero means the list is empty.
- R9: Memory port rules: `mem_we` is only high together with `mem_en`. Read data is taken from `mem_rdata` in the cycle after the read request. `mem_en` is 0 whenever no list operation is in progress.
- R10: Arbitration: a `leave` handshake wins over quantum expiry, expiry wins over wake-up, and wake-up wins over add. `add_ready` is 0 whenever `wake_valid` is 1.
- R11: Back-pressure: `add_ready`, `wake_ready` and `leave_ready` are all 0 while a list operation is in flight. A requester holds valid high with a stable payload until it sees ready, and the transfer happens in the cycle where both are high.
- R12: `leave_ready` is only high while a task is current. A `leave_valid` with an empty list has no effect.
- R13: `switch_pulse` lasts one cycle. It occurs only when `cur_task` has just changed to a valid task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_valid | input | 1 | New task request valid |
| add_ready | output | 1 | New task request accepted |
| add_task | input | AW | Descriptor address of new task (nonzero) |
| wake_valid | input | 1 | Woken task request valid |
| wake_ready | output | 1 | Woken task request accepted |
| wake_task | input | AW | Descriptor address of woken task (nonzero) |
| leave_valid | input | 1 | Current task terminates or blocks |
| leave_ready | output | 1 | Leave request accepted |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, one cycle after the read request |
| cur_valid | output | 1 | A task is current |
| cur_task | output | AW | Descriptor address of current task |
| switch_pulse | output | 1 | One-cycle pulse when a new task becomes current |

## Verification
The bench builds the block with `AW`=8, `QUANTUM`=20 and `NEXT_OFS`=1. The short quantum lets many rotations and exact pulse spacings fit into a short run. The nonzero offset exercises the link-address adder rather than the direct path. With 8-bit pointers, the bench's memory model can cover the whole address space. That memory starts out filled with all ones, so a missing null write corrupts the list and shows up in the walk of the links or in the switch order.

// File: rtl/rr_sched_pkg.sv
package rr_sched_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AP_CLR,
    ST_AP_LINK,
    ST_LV_RD,
    ST_LV_TAKE,
    ST_RT_RD,
    ST_RT_CLR,
    ST_RT_LINK
  } eng_state_e;

endpackage

// File: rtl/rr_quantum_timer.sv
module rr_quantum_timer #(
  parameter int QUANTUM = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic done
);
  localparam int CW = $clog2(QUANTUM + 1);
  localparam logic [CW-1:0] LAST = CW'(QUANTUM - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || !run) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/rr_req_arbiter.sv
module rr_req_arbiter #(
  parameter int AW = 16
) (
  input  logic          open,
  input  logic          wake_valid,
  input  logic [AW-1:0] wake_task,
  input  logic          add_valid,
  input  logic [AW-1:0] add_task,
  output logic          wake_ready,
  output logic          add_ready,
  output logic          grant,
  output logic [AW-1:0] grant_task
);
  // wake-up outranks a fresh task
  assign wake_ready = open;
  assign add_ready  = open && !wake_valid;
  assign grant      = open && (wake_valid || add_valid);
  assign grant_task = wake_valid ? wake_task : add_task;
endmodule

// File: rtl/rr_list_engine.sv
module rr_list_engine
  import rr_sched_pkg::*;
#(
  parameter int AW       = 16,
  parameter int NEXT_OFS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              leave_go,
  input  logic              expire_go,
  input  logic              app_go,
  input  logic [AW-1:0]     app_task,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [AW-1:0]     front,
  output logic              idle,
  output logic              take,
  output logic              restart
);
  eng_state_e    state_q, state_d;
  logic [AW-1:0] front_q, front_d, rear_q, rear_d, tmp_q, tmp_d;
  logic [AW-1:0] front_link, rear_link, tmp_link;
  logic [AW-1:0] rd_ptr;
  logic          rd_null;

  generate
    if (NEXT_OFS == 0) begin : g_direct
      assign front_link = front_q;
      assign rear_link  = rear_q;
      assign tmp_link   = tmp_q;
    end else begin : g_offset
      assign front_link = front_q + AW'(NEXT_OFS);
      assign rear_link  = rear_q + AW'(NEXT_OFS);
      assign tmp_link   = tmp_q + AW'(NEXT_OFS);
    end
  endgenerate

  assign rd_ptr  = mem_rdata[AW-1:0];
  assign rd_null = (mem_rdata == '0);
  assign idle    = (state_q == ST_IDLE);
  assign front   = front_q;
  assign restart = idle && !leave_go && expire_go && (front_q == rear_q);

  always_comb begin
    state_d   = state_q;
    front_d   = front_q;
    rear_d    = rear_q;
    tmp_d     = tmp_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    take      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (leave_go) begin
          state_d = ST_LV_RD;
        end else if (expire_go && (front_q != rear_q)) begin
          state_d = ST_RT_RD;
        end else if (app_go) begin
          tmp_d   = app_task;
          state_d = ST_AP_CLR;
        end
      end
      ST_AP_CLR: begin
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        mem_addr = tmp_link;
        state_d  = ST_AP_LINK;
      end
      ST_AP_LINK: begin
        if (front_q == '0) begin
          front_d = tmp_q;
          rear_d  = tmp_q;
          take    = 1'b1;
        end else begin
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = rear_link;
          mem_wdata = WORD_W'(tmp_q);
          rear_d    = tmp_q;
        end
        state_d = ST_IDLE;
      end
      ST_LV_RD: begin
        mem_en   = 1'b1;
        mem_addr = front_link;
        state_d  = ST_LV_TAKE;
      end
      ST_LV_TAKE: begin
        if (rd_null) begin
          front_d = '0;
          rear_d  = '0;
        end else begin
          front_d = rd_ptr;
          take    = 1'b1;
        end
        state_d = ST_IDLE;
      end
      ST_RT_RD: begin
        mem_en   = 1'b1;
        mem_addr = front_link;
        state_d  = ST_RT_CLR;
      end
      ST_RT_CLR: begin
        tmp_d    = rd_ptr;
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        mem_addr = front_link;
        state_d  = ST_RT_LINK;
      end
      ST_RT_LINK: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = rear_link;
        mem_wdata = WORD_W'(front_q);
        rear_d    = front_q;
        front_d   = tmp_q;
        take      = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      front_q <= '0;
      rear_q  <= '0;
      tmp_q   <= '0;
    end else begin
      state_q <= state_d;
      front_q <= front_d;
      rear_q  <= rear_d;
      tmp_q   <= tmp_d;
    end
  end
endmodule

// File: rtl/rr_task_sched.sv
module rr_task_sched
  import rr_sched_pkg::*;
#(
  parameter int AW       = 16,
  parameter int QUANTUM  = 64,
  parameter int NEXT_OFS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_valid,
  output logic              add_ready,
  input  logic [AW-1:0]     add_task,
  input  logic              wake_valid,
  output logic              wake_ready,
  input  logic [AW-1:0]     wake_task,
  input  logic              leave_valid,
  output logic              leave_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              cur_valid,
  output logic [AW-1:0]     cur_task,
  output logic              switch_pulse
);
  logic          eng_idle, take, restart, tmr_done;
  logic          leave_go, expire_go, arb_open, grant;
  logic [AW-1:0] front, grant_task;
  logic          pulse_q;

  assign cur_valid   = (front != '0);
  assign cur_task    = front;
  assign leave_ready = eng_idle && cur_valid;
  assign leave_go    = leave_valid && leave_ready;
  assign expire_go   = eng_idle && tmr_done && !leave_go;
  assign arb_open    = eng_idle && !leave_go && !expire_go;

  rr_quantum_timer #(.QUANTUM(QUANTUM)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cur_valid),
    .clear (take || restart),
    .done  (tmr_done)
  );

  rr_req_arbiter #(.AW(AW)) u_arb (
    .open       (arb_open),
    .wake_valid (wake_valid),
    .wake_task  (wake_task),
    .add_valid  (add_valid),
    .add_task   (add_task),
    .wake_ready (wake_ready),
    .add_ready  (add_ready),
    .grant      (grant),
    .grant_task (grant_task)
  );

  rr_list_engine #(.AW(AW), .NEXT_OFS(NEXT_OFS)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .leave_go  (leave_go),
    .expire_go (expire_go),
    .app_go    (grant),
    .app_task  (grant_task),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .front     (front),
    .idle      (eng_idle),
    .take      (take),
    .restart   (restart)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= take;
  end
  assign switch_pulse = pulse_q;
endmodule

// File: rtl/rr_task_sched_chk.sv
module rr_task_sched_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          add_ready,
  input logic          wake_valid,
  input logic          wake_ready,
  input logic          leave_ready,
  input logic          mem_en,
  input logic          mem_we,
  input logic          cur_valid,
  input logic [AW-1:0] cur_task,
  input logic          switch_pulse
);
  a_r13_pulse_changes: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (cur_valid && (cur_task != $past(cur_task))));

  a_r13_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |=> !switch_pulse);

  a_r9_write_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  a_r10_wake_first: assert property (@(posedge clk) disable iff (!rst_n)
    add_ready |-> !wake_valid);

  a_r12_leave_needs_task: assert property (@(posedge clk) disable iff (!rst_n)
    leave_ready |-> cur_valid);

  a_r11_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (!add_ready && !wake_ready && !leave_ready));
endmodule

bind rr_task_sched rr_task_sched_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .add_ready    (add_ready),
  .wake_valid   (wake_valid),
  .wake_ready   (wake_ready),
  .leave_ready  (leave_ready),
  .mem_en       (mem_en),
  .mem_we       (mem_we),
  .cur_valid    (cur_valid),
  .cur_task     (cur_task),
  .switch_pulse (switch_pulse)
);

// File: tb/rr_task_sched_test.sv
`timescale 1ns/1ps
module rr_task_sched_test;
  localparam int AW  = 8;
  localparam int Q   = 20;
  localparam int OFS = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          add_valid = 1'b0, wake_valid = 1'b0, leave_valid = 1'b0;
  logic [AW-1:0] add_task = '0, wake_task = '0;
  logic          add_ready, wake_ready, leave_ready;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          cur_valid, switch_pulse;
  logic [AW-1:0] cur_task;

  logic [31:0]   mem [0:(1<<AW)-1];
  logic [AW-1:0] expq[$];
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  localparam logic [AW-1:0] TA = 8'h10, TB = 8'h20, TC = 8'h30, TD = 8'h40, TE = 8'h50;

  always #10 clk = ~clk;

  rr_task_sched #(.AW(AW), .QUANTUM(Q), .NEXT_OFS(OFS)) uut (
    .clk(clk), .rst_n(rst_n),
    .add_valid(add_valid), .add_ready(add_ready), .add_task(add_task),
    .wake_valid(wake_valid), .wake_ready(wake_ready), .wake_task(wake_task),
    .leave_valid(leave_valid), .leave_ready(leave_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cur_valid(cur_valid), .cur_task(cur_task), .switch_pulse(switch_pulse)
  );

  // memory model: registered read, one cycle latency
  initial for (int i = 0; i < (1<<AW); i++) mem[i] = 32'hFFFF_FFFF;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && switch_pulse) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R13 unexpected switch: actual %0h expected none", cur_task);
      end else begin
        logic [AW-1:0] e;
        e = expq.pop_front();
        chk("R3 switch order", 32'(cur_task), 32'(e));
      end
    end
  end

  task automatic wait_pulse(output int t);
    do @(negedge clk); while (!switch_pulse);
    t = cyc;
  endtask

  task automatic send_add(input logic [AW-1:0] t, output int h);
    add_task = t; add_valid = 1'b1; #1;
    while (!add_ready) begin @(negedge clk); #1; end
    h = cyc;
    @(negedge clk); add_valid = 1'b0;
  endtask

  task automatic send_leave(output int h);
    leave_valid = 1'b1; #1;
    while (!leave_ready) begin @(negedge clk); #1; end
    h = cyc;
    @(negedge clk); leave_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int h, t1, t2, tp;
    repeat (3) @(negedge clk);
    chk("R1 cur_valid in reset", cur_valid, 0);
    chk("R1 mem_en in reset", mem_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cur_valid", cur_valid, 0);
    chk("R1 switch_pulse", switch_pulse, 0);
    chk("R1 leave_ready", leave_ready, 0);
    chk("R1 add_ready", add_ready, 1);
    chk("R1 wake_ready", wake_ready, 1);
    chk("R9 mem idle", mem_en, 0);

    // R2: add to empty list
    expq.push_back(TA);
    send_add(TA, h);
    chk("R11 add_ready low while busy", add_ready, 0);
    wait_pulse(tp);
    chk("R2 latency", tp - h, 3);
    chk("R8 null link of sole task", mem[TA+OFS], 0);

    // R5: single task, no switch for three quanta
    repeat (3*Q) @(negedge clk);
    chk("R5 still current", 32'(cur_task), 32'(TA));

    // R3/R4: rotation
    expq.push_back(TB); expq.push_back(TC); expq.push_back(TA);
    send_add(TB, h);
    send_add(TC, h);
    wait_pulse(t1);
    wait_pulse(t2);
    chk("R4 quantum spacing", t2 - t1, Q + 3);
    wait_pulse(tp);

    // R10: wake and add together, wake wins
    expq.push_back(TB); expq.push_back(TC); expq.push_back(TD);
    expq.push_back(TE); expq.push_back(TA);
    wake_task = TD; wake_valid = 1'b1;
    add_task = TE; add_valid = 1'b1; #1;
    chk("R10 wake_ready", wake_ready, 1);
    chk("R10 add_ready blocked", add_ready, 0);
    @(negedge clk); wake_valid = 1'b0; #1;
    chk("R11 add held during op", add_ready, 0);
    while (!add_ready) begin @(negedge clk); #1; end
    @(negedge clk); add_valid = 1'b0;
    for (int k = 0; k < 5; k++) wait_pulse(tp);
    chk("R8 link A", mem[TA+OFS], 32'(TB));
    chk("R8 link B", mem[TB+OFS], 32'(TC));
    chk("R8 link C", mem[TC+OFS], 32'(TD));
    chk("R8 link D", mem[TD+OFS], 32'(TE));
    chk("R8 tail null", mem[TE+OFS], 0);

    // R6: leave
    expq.push_back(TB);
    send_leave(h);
    chk("R11 leave_ready low while busy", leave_ready, 0);
    wait_pulse(tp);
    chk("R6 leave latency", tp - h, 3);
    expq.push_back(TC); send_leave(h); wait_pulse(tp);
    expq.push_back(TD); send_leave(h); wait_pulse(tp);
    expq.push_back(TE); send_leave(h); wait_pulse(tp);

    // R7: last task leaves
    send_leave(h);
    repeat (4) @(negedge clk);
    chk("R7 list empty", cur_valid, 0);
    chk("R7 add accepted", add_ready, 1);
    chk("R12 leave_ready empty", leave_ready, 0);

    // R12: leave request on empty list ignored
    leave_valid = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 still empty", cur_valid, 0);
    leave_valid = 1'b0;

    // R7/R2: refill after empty
    expq.push_back(TC);
    send_add(TC, h);
    wait_pulse(tp);
    chk("R7 refill latency", tp - h, 3);
    chk("R8 refill null", mem[TC+OFS], 0);
    repeat (2*Q) @(negedge clk);
    chk("R5 sole task kept", 32'(cur_task), 32'(TC));
    chk("R6 left tasks not requeued", 32'(expq.size()), 0);
    chk("R9 port idle", mem_en, 0);
    finish_run();
  end
endmodule